// File: doc/BRIEF.md
# Dual-Class Maskable Interrupt Controller

This block gathers interrupt requests from a set of devices split into two independent classes: a normal class and a fast class. Each class numbers its devices from zero. Each class has its own mask register and its own request latches. A parameter marks every source as edge type or level type. An edge-type source sets a sticky latch bit on a rising edge of its input. A level-type source is pending for as long as its input is high.

Software controls the block with single-cycle commands. A command can unmask a source, mask a source, clear a latched request, ask which source is pending, or ask about the raw request of one source. The fast class also has one command that masks all of its sources at once.

For each class the block presents the highest-priority pending, unmasked source on a combinational output. Priority is fixed: the lowest device number wins. The block also drives one registered interrupt line per class to the processor.

Commands enter on a plain strobe, `cmd_vld`. There is no back-pressure: a command is accepted in every cycle that `cmd_vld` is high. The reply appears on `rsp_vld`/`rsp_data` for exactly one cycle, one clock after the command, and it cannot be stalled.

Top module: `irq_ctrl2`

## Requirements
- R1: Op code 0 (enable) sets the mask bit of the addressed source. Its reply is 1 if that bit was already set before the command and 0 otherwise.
- R2: Op code 1 (disable) clears the mask bit of the addressed source. Its reply is 1 if that bit was set before the command and 0 otherwise.
- R3: Op code 2 (clear) removes the latched request of an edge-type source. It has no effect on a level-type source. Its reply is 0.
- R4: `src_nrm` and `src_fst` give the lowest-numbered source of their class that is both pending and unmasked. When no such source exists they give all ones. Op code 3 (source query) replies with the same value for the selected class, sampled in the command cycle.
- R5: Op code 4 (status) replies 1 when the addressed source is requesting and 0 otherwise, whatever its mask bit. "Requesting" means the latch bit for an edge-type source and the input level for a level-type source.
- R6: `cmd_cls` selects the class: 0 is normal and 1 is fast. A command changes only the state of the class it selects.
- R7: Op code 5 (mask all) clears every fast mask bit when sent to the fast class. Sent to the normal class it has no effect. Its reply is 0.
- R8: Each of `irq_nrm` and `irq_fst` is high one cycle after its class has a pending, unmasked source, and low one cycle after it has none.
- R9: An edge-type latch bit is set by a rising input edge and holds until it is cleared. A rising edge in the same cycle as a clear of that source leaves the bit set.
- R10: Reset clears all masks, all latches and both interrupt lines. Out of reset, both source outputs are all ones.
- R11: `rsp_vld` is high exactly one cycle after `cmd_vld`. In the following cases the block changes no state and replies 0: a device number at or beyond the class size, op codes 6 and 7, and op code 5 sent to the normal class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_nrm | input | NN | Normal-class device request lines |
| req_fst | input | NF | Fast-class device request lines |
| cmd_vld | input | 1 | Command strobe, accepted every cycle |
| cmd_op | input | 3 | Op code: 0 enable, 1 disable, 2 clear, 3 source, 4 status, 5 mask all |
| cmd_cls | input | 1 | Class select: 0 normal, 1 fast |
| cmd_dev | input | DW | Device number within the class |
| rsp_vld | output | 1 | Reply valid, one cycle after the command |
| rsp_data | output | DW | Reply value |
| src_nrm | output | DW | Highest-priority pending unmasked normal source, all ones if none |
| src_fst | output | DW | Highest-priority pending unmasked fast source, all ones if none |
| irq_nrm | output | 1 | Registered normal interrupt line |
| irq_fst | output | 1 | Registered fast interrupt line |

## Verification
The bench aims at the following corner cases, each with the symptom a wrong design would show:
- A rising edge that arrives in the same cycle as a clear of that source. A design that lets the clear win loses the interrupt, which shows up as a wrong status reply.
- A clear sent to a level-type source. A design that applies it would drop a request the device still holds.
- Enable and disable replies for sources already in the target state. A design that reports the new state instead of the prior one gets these wrong.
- Out-of-range device numbers, undefined op codes, and mask-all sent to the normal class. A design that decodes these would corrupt state in the other class, or mask sources it should leave alone.

// File: rtl/irq_ctrl2_pkg.sv
package irq_ctrl2_pkg;
  typedef enum logic [2:0] {
    OP_EN   = 3'd0,
    OP_DIS  = 3'd1,
    OP_CLR  = 3'd2,
    OP_SRC  = 3'd3,
    OP_STAT = 3'd4,
    OP_MALL = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } irq_op_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic [N-1:0]  vec_i,
  output logic [DW-1:0] code_o
);
  always_comb begin
    code_o = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) code_o = DW'(i);
    end
  end
endmodule

// File: rtl/irq_class.sv
module irq_class
  import irq_ctrl2_pkg::*;
#(
  parameter int          N     = 8,
  parameter int          DW    = 8,
  parameter logic [N-1:0] EDGE = '0,
  parameter bit          MALL  = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic          hit_i,
  input  irq_op_e       op_i,
  input  logic [DW-1:0] dev_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] src_o,
  output logic          irq_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [DW-1:0] NONE = '1;

  logic [N-1:0] prev_q, lat_q, mask_q, lat_d, mask_d;
  logic [N-1:0] pend, rise, onehot, clr_vec;
  logic [IW-1:0] idx;
  logic in_rng;

  assign in_rng = (dev_i < DW'(N));
  assign idx    = dev_i[IW-1:0];
  assign onehot = in_rng ? (N'(1) << idx) : '0;
  assign rise   = req_i & ~prev_q & EDGE;

  for (genvar g = 0; g < N; g++) begin : g_pend
    if (EDGE[g]) begin : g_edge
      assign pend[g] = lat_q[g];
    end else begin : g_lvl
      assign pend[g] = req_i[g];
    end
  end

  irq_prio_pick #(.N(N), .DW(DW)) u_pick (.vec_i(pend & mask_q), .code_o(src_o));

  assign clr_vec = (hit_i && op_i == OP_CLR) ? (onehot & EDGE) : '0;
  assign lat_d   = (lat_q & ~clr_vec) | rise;

  always_comb begin
    mask_d = mask_q;
    if (hit_i) begin
      case (op_i)
        OP_EN:   mask_d = mask_q | onehot;
        OP_DIS:  mask_d = mask_q & ~onehot;
        OP_MALL: if (MALL) mask_d = '0;
        default: mask_d = mask_q;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (op_i)
      OP_EN, OP_DIS: if (in_rng) rdata_o = {{(DW-1){1'b0}}, mask_q[idx]};
      OP_SRC:        rdata_o = src_o;
      OP_STAT:       if (in_rng) rdata_o = {{(DW-1){1'b0}}, pend[idx]};
      default:       rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      lat_q  <= '0;
      mask_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      prev_q <= req_i;
      lat_q  <= lat_d;
      mask_q <= mask_d;
      irq_o  <= |(pend & mask_q);
    end
  end

  // R1
  en_sets_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_i && op_i == OP_EN && in_rng) |=> mask_q[$past(idx)]);
  // R2
  dis_clears_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_i && op_i == OP_DIS && in_rng) |=> !mask_q[$past(idx)]);
  // R9
  edge_wins_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|(rise & clr_vec)) |=> (|(lat_q & $past(clr_vec))));
  // R4
  src_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (src_o != NONE) |-> (mask_q[src_o[IW-1:0]] && pend[src_o[IW-1:0]]));
  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (src_o == NONE) |=> !irq_o);

  if (MALL) begin : g_mall_chk
    // R7
    mask_all_chk: assert property (@(posedge clk) disable iff (rst)
      (hit_i && op_i == OP_MALL) |=> (mask_q == '0));
  end
endmodule

// File: rtl/irq_ctrl2.sv
module irq_ctrl2
  import irq_ctrl2_pkg::*;
#(
  parameter int           NN     = 8,
  parameter int           NF     = 4,
  parameter int           DW     = 8,
  parameter logic [NN-1:0] EDGE_N = 8'h0F,
  parameter logic [NF-1:0] EDGE_F = 4'h3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NN-1:0] req_nrm,
  input  logic [NF-1:0] req_fst,
  input  logic          cmd_vld,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_cls,
  input  logic [DW-1:0] cmd_dev,
  output logic          rsp_vld,
  output logic [DW-1:0] rsp_data,
  output logic [DW-1:0] src_nrm,
  output logic [DW-1:0] src_fst,
  output logic          irq_nrm,
  output logic          irq_fst
);
  irq_op_e op;
  logic [DW-1:0] rd_n, rd_f;

  assign op = irq_op_e'(cmd_op);

  irq_class #(.N(NN), .DW(DW), .EDGE(EDGE_N), .MALL(1'b0)) u_nrm (
    .clk(clk), .rst(rst), .req_i(req_nrm), .hit_i(cmd_vld && !cmd_cls),
    .op_i(op), .dev_i(cmd_dev), .rdata_o(rd_n), .src_o(src_nrm), .irq_o(irq_nrm));

  irq_class #(.N(NF), .DW(DW), .EDGE(EDGE_F), .MALL(1'b1)) u_fst (
    .clk(clk), .rst(rst), .req_i(req_fst), .hit_i(cmd_vld && cmd_cls),
    .op_i(op), .dev_i(cmd_dev), .rdata_o(rd_f), .src_o(src_fst), .irq_o(irq_fst));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld  <= 1'b0;
      rsp_data <= '0;
    end else begin
      rsp_vld  <= cmd_vld;
      rsp_data <= cmd_vld ? (cmd_cls ? rd_f : rd_n) : '0;
    end
  end

  // R11
  rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |=> rsp_vld);
  // R11
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_vld |=> (!rsp_vld && rsp_data == '0));
endmodule

// File: tb/sim_irq_ctrl2.sv
module sim_irq_ctrl2;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_n = '0;
  logic [3:0] req_f = '0;
  logic       cmd_vld = 1'b0;
  logic [2:0] cmd_op = '0;
  logic       cmd_cls = 1'b0;
  logic [7:0] cmd_dev = '0;
  logic       rsp_vld, irq_n, irq_f;
  logic [7:0] rsp_data, src_n, src_f;

  irq_ctrl2 u0 (
    .clk(clk), .rst(rst), .req_nrm(req_n), .req_fst(req_f),
    .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_cls(cmd_cls), .cmd_dev(cmd_dev),
    .rsp_vld(rsp_vld), .rsp_data(rsp_data), .src_nrm(src_n), .src_fst(src_f),
    .irq_nrm(irq_n), .irq_fst(irq_f));

  always #(CLK_PER/2) clk = ~clk;

  localparam logic [7:0] EN_N = 8'h0F;
  localparam logic [3:0] EN_F = 4'h3;

  int total = 0, bad = 0, cycles = 0;

  // behavioural reference state
  logic [7:0] m_mn, m_ln, m_pn;
  logic [3:0] m_mf, m_lf, m_pf;
  logic       m_irqn, m_irqf, m_rv;
  logic [7:0] m_rd;
  string      m_tag = "R10";

  function automatic logic [7:0] pick(input logic [7:0] v, input int lim);
    logic [7:0] r = 8'hFF;
    for (int i = lim - 1; i >= 0; i--) if (v[i]) r = 8'(i);
    return r;
  endfunction

  function automatic logic [7:0] pend_n();
    return (m_ln & EN_N) | (req_n & ~EN_N);
  endfunction
  function automatic logic [3:0] pend_f();
    return (m_lf & EN_F) | (req_f & ~EN_F);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mn = '0; m_ln = '0; m_pn = '0; m_mf = '0; m_lf = '0; m_pf = '0;
      m_irqn = 0; m_irqf = 0; m_rv = 0; m_rd = '0; m_tag = "R10";
    end else begin
      logic [7:0] pn, clrn, mn;
      logic [3:0] pf, clrf, mf;
      int d, lim;
      pn = pend_n(); pf = pend_f();
      m_irqn = |(pn & m_mn);
      m_irqf = |(pf & m_mf);
      m_rv = cmd_vld; m_rd = '0;
      clrn = '0; clrf = '0; mn = m_mn; mf = m_mf;
      if (cmd_vld) begin
        logic [7:0] curm, curp;
        d = int'(cmd_dev);
        lim = cmd_cls ? 4 : 8;
        curm = cmd_cls ? {4'h0, m_mf} : m_mn;
        curp = cmd_cls ? {4'h0, pf} : pn;
        case (cmd_op)
          3'd0: begin m_tag = "R1"; if (d < lim) begin m_rd = {7'd0, curm[d]}; curm[d] = 1'b1; end end
          3'd1: begin m_tag = "R2"; if (d < lim) begin m_rd = {7'd0, curm[d]}; curm[d] = 1'b0; end end
          3'd2: begin m_tag = "R3"; if (d < lim) begin
                  if (cmd_cls) clrf[d] = 1'b1; else clrn[d] = 1'b1; end end
          3'd3: begin m_tag = "R4"; m_rd = pick(curp & curm, lim); end
          3'd4: begin m_tag = "R5"; if (d < lim) m_rd = {7'd0, curp[d]}; end
          3'd5: begin m_tag = "R7"; if (cmd_cls) curm = '0; end
          default: m_tag = "R11";
        endcase
        if (d >= lim && cmd_op != 3'd3 && cmd_op != 3'd5) m_tag = "R11";
        if (cmd_cls) mf = curm[3:0]; else mn = curm;
      end else m_tag = "R11";
      m_mn = mn; m_mf = mf;
      m_ln = (m_ln & ~clrn) | (req_n & ~m_pn & EN_N);
      m_lf = (m_lf & ~clrf) | (req_f & ~m_pf & EN_F);
      m_pn = req_n; m_pf = req_f;
    end
  end

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R8", "irq_nrm", {7'd0, irq_n}, {7'd0, m_irqn});
      chk("R8", "irq_fst", {7'd0, irq_f}, {7'd0, m_irqf});
      chk("R4", "src_nrm", src_n, pick(pend_n() & m_mn, 8));
      chk("R6", "src_fst", src_f, pick({4'h0, pend_f() & m_mf}, 4));
      chk("R11", "rsp_vld", {7'd0, rsp_vld}, {7'd0, m_rv});
      chk(m_tag, "rsp_data", rsp_data, m_rd);
    end
  end

  task automatic cmd(input logic [2:0] op, input logic cls, input logic [7:0] dev);
    @(posedge clk); #1;
    cmd_vld = 1'b1; cmd_op = op; cmd_cls = cls; cmd_dev = dev;
    @(posedge clk); #1;
    cmd_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10", "src_nrm reset", src_n, 8'hFF);
    chk("R10", "src_fst reset", src_f, 8'hFF);
    chk("R10", "irq reset", {6'd0, irq_n, irq_f}, 8'h00);

    // R1 / R2 prior-state replies, R4 level source
    req_n[5] = 1'b1;
    cmd(3'd0, 1'b0, 8'd5);   // R1: reply 0
    cmd(3'd0, 1'b0, 8'd5);   // R1: reply 1
    idle(2);
    cmd(3'd3, 1'b0, 8'd0);   // R4: reply 5
    cmd(3'd2, 1'b0, 8'd5);   // R3: level source unaffected
    idle(2);
    cmd(3'd1, 1'b0, 8'd5);   // R2: reply 1
    cmd(3'd1, 1'b0, 8'd5);   // R2: reply 0
    req_n[5] = 1'b0;

    // R9 edge coincident with clear keeps latch
    cmd(3'd0, 1'b1, 8'd0);
    @(posedge clk); #1;
    req_f[0] = 1'b1; cmd_vld = 1'b1; cmd_op = 3'd2; cmd_cls = 1'b1; cmd_dev = 8'd0;
    @(posedge clk); #1;
    cmd_vld = 1'b0;
    cmd(3'd4, 1'b1, 8'd0);   // R9 status reply 1
    idle(2);
    cmd(3'd2, 1'b1, 8'd0);   // R3 clear edge latch
    cmd(3'd4, 1'b1, 8'd0);   // reply 0
    req_f[0] = 1'b0;

    // R6 / R7 class independence and mask-all
    cmd(3'd0, 1'b0, 8'd2);
    cmd(3'd5, 1'b0, 8'd0);   // R7 ignored on normal class
    cmd(3'd0, 1'b0, 8'd2);   // reply 1 shows the mask survived
    cmd(3'd0, 1'b1, 8'd2);
    cmd(3'd0, 1'b1, 8'd3);
    cmd(3'd5, 1'b1, 8'd0);   // R7
    cmd(3'd1, 1'b1, 8'd3);   // reply 0
    cmd(3'd0, 1'b0, 8'd9);   // R11 out of range
    cmd(3'd6, 1'b1, 8'd1);   // R11 reserved op

    // mixed pseudo-random traffic
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_vld = lfsr[0] | lfsr[1];
      cmd_op  = (lfsr[4:2] == 3'd5 && !lfsr[11] && !lfsr[12]) ? 3'd0 : lfsr[4:2];
      cmd_cls = lfsr[5];
      cmd_dev = {4'd0, lfsr[9:6]} % 8'd10;
      if (lfsr[10] && lfsr[14]) req_n[lfsr[8:6]] = ~req_n[lfsr[8:6]];
      if (lfsr[11] && lfsr[15]) req_f[lfsr[3:2]] = ~req_f[lfsr[3:2]];
    end
    @(posedge clk); #1;
    cmd_vld = 1'b0;
    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule